// File: doc/BRIEF.md
# Serial Flash Write-Enable and Block-Lock Register File

This block keeps the control and status state that a serial NAND flash device exposes to its host. A serial front end decodes each command and passes it on as a single-cycle strobe. This block uses those strobes to set or clear the write-enable latch, and to update or read back the feature bytes. It also decides whether a program or erase may be launched to the array sequencer, and it turns a reset command into either an abort or a status clear.

Three feature bytes are implemented, each at a one-byte address:

- **Protection byte (address A0h).** Holds the block-lock level, the invert and complement modifiers, and the hardware-guard bit. The hardware-guard bit works with the write-protect pin. While the guard is set and the pin is low, the whole protection byte is frozen.
- **Configuration byte (address B0h).** Holds the ECC-enable bit that the ECC neighbour reads.
- **Status byte (address C0h).** Read-only. It reports busy, the latch, the program and erase failure flags, and the ECC result.

Array completions come back as a done pulse with the operation kind, a fail flag and an ECC code.

Top module: `flash_wp_feature_regs`

## Requirements
- R1: After the synchronous reset `rst`, the protection byte reads 07h (all blocks locked, guard clear), the configuration byte reads 00h, the status byte reads 00h with `arr_busy` low, and `feat_rdata`, `launch_go` and `abort_op` are 0.
- R2: `cmd_wren` sets the write-enable latch and `cmd_wrdis` clears it. The latch reads back as status bit 1.
- R3: A set-feature to A0h stores the lock level in data bits 2:0, invert in bit 3, complement in bit 4 and the guard in bit 7. Bits 6:5 read back as 0.
- R4: While the guard bit is 1 and `wp_n` is 0, `lock_wr_ok` is 0 and a set-feature to A0h leaves the whole protection byte unchanged. Otherwise `lock_wr_ok` is 1.
- R5: A get-feature drives the addressed byte on `feat_rdata` one cycle after the strobe. Any address other than A0h, B0h or C0h returns 00h, and a set-feature to such an address, or to C0h, changes nothing.
- R6: A program-execute or erase strobe while idle and with the latch set gives one cycle of `launch_go` on the next cycle. `launch_kind` is 1 for program and 2 for erase. A page-read strobe while idle launches kind 0 without needing the latch. No launch occurs while `arr_busy` is high, or for program or erase while the latch is clear.
- R7: An `op_done` pulse of kind 1 or 2 clears the latch. It also records `op_fail` into the program-fail flag (status bit 3) or the erase-fail flag (status bit 2). An `op_done` of kind 0 records `op_ecc` into status bits 5:4.
- R8: A reset strobe while `arr_busy` is high pulses `abort_op` on the next cycle and keeps the failure and ECC flags. While idle it raises no abort and clears status bits 5:2.
- R9: A set-feature to B0h stores data bit 4 as ECC enable. All other configuration bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdis | input | 1 | Write-disable command strobe |
| cmd_setf | input | 1 | Set-feature command strobe |
| cmd_getf | input | 1 | Get-feature command strobe |
| cmd_rst | input | 1 | Reset command strobe |
| cmd_prog | input | 1 | Program-execute command strobe |
| cmd_erase | input | 1 | Block-erase command strobe |
| cmd_pgrd | input | 1 | Page-read command strobe |
| feat_addr | input | 8 | Feature byte address |
| feat_wdata | input | 8 | Set-feature data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| arr_busy | input | 1 | Array operation in progress |
| op_done | input | 1 | Array operation finished (one cycle) |
| op_kind | input | 2 | Kind of the finished operation: 0 read, 1 program, 2 erase |
| op_fail | input | 1 | Finished program or erase failed |
| op_ecc | input | 2 | ECC result of a finished read |
| feat_rdata | output | 8 | Get-feature read data |
| lock_wr_ok | output | 1 | Protection byte may be written |
| launch_go | output | 1 | Start an array operation (one cycle) |
| launch_kind | output | 2 | Kind of the launched operation |
| abort_op | output | 1 | Abort the array operation in progress (one cycle) |

## Verification
Every registered result is due one clock after its strobe:

- a get-feature's data, a launch and an abort appear on the cycle after the strobe;
- a latch, flag or feature-byte update is visible through a get-feature issued on the next cycle, so its data arrives one cycle later again.

The bench raises each strobe on a falling edge and lowers it on the following falling edge. It samples the outputs at that same point, half a period after the capturing rising edge. `lock_wr_ok` is combinational and is sampled in the same cycle that `wp_n` or the guard changes.

// File: rtl/flash_feat_pkg.sv
package flash_feat_pkg;
    parameter int BYTE_W = 8;
    parameter logic [BYTE_W-1:0] ADDR_PROT = 8'hA0;
    parameter logic [BYTE_W-1:0] ADDR_CFG  = 8'hB0;
    parameter logic [BYTE_W-1:0] ADDR_STAT = 8'hC0;
    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        OPK_READ  = 2'd0,
        OPK_PROG  = 2'd1,
        OPK_ERASE = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic             guard;
        logic             cmpl;
        logic             inv;
        logic [LVL_W-1:0] level;
    } prot_t;

    typedef struct packed {
        logic                  wel;
        prot_t                 prot;
        logic                  ecc_en;
        logic                  prog_fail;
        logic                  erase_fail;
        logic [1:0]            ecc_st;
        logic [BYTE_W-1:0]     rdata;
        logic                  launch;
        logic [1:0]            launch_kind;
        logic                  abort;
    } regs_t;
endpackage

// File: rtl/lock_guard.sv
module lock_guard (
    input  logic guard,
    input  logic wp_n,
    output logic allow
);
    always_comb begin
        allow = 1'b1;
        if (guard && !wp_n) allow = 1'b0;
    end
endmodule

// File: rtl/feat_mux.sv
module feat_mux #(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] A_PROT = 8'hA0,
    parameter logic [BYTE_W-1:0] A_CFG  = 8'hB0,
    parameter logic [BYTE_W-1:0] A_STAT = 8'hC0
) (
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] prot_byte,
    input  logic [BYTE_W-1:0] cfg_byte,
    input  logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] rbyte
);
    always_comb begin
        rbyte = '0;
        if (addr == A_PROT) rbyte = prot_byte;
        else if (addr == A_CFG) rbyte = cfg_byte;
        else if (addr == A_STAT) rbyte = stat_byte;
    end
endmodule

// File: rtl/op_gate.sv
module op_gate (
    input  logic       wel,
    input  logic       busy,
    input  logic       do_prog,
    input  logic       do_erase,
    input  logic       do_read,
    output logic       go,
    output logic [1:0] kind
);
    import flash_feat_pkg::*;
    always_comb begin
        go   = 1'b0;
        kind = OPK_READ;
        if (!busy) begin
            if (do_prog && wel) begin
                go   = 1'b1;
                kind = OPK_PROG;
            end else if (do_erase && wel) begin
                go   = 1'b1;
                kind = OPK_ERASE;
            end else if (do_read) begin
                go   = 1'b1;
                kind = OPK_READ;
            end
        end
    end
endmodule

// File: rtl/flash_wp_feature_regs.sv
module flash_wp_feature_regs
    import flash_feat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wren,
    input  logic              cmd_wrdis,
    input  logic              cmd_setf,
    input  logic              cmd_getf,
    input  logic              cmd_rst,
    input  logic              cmd_prog,
    input  logic              cmd_erase,
    input  logic              cmd_pgrd,
    input  logic [BYTE_W-1:0] feat_addr,
    input  logic [BYTE_W-1:0] feat_wdata,
    input  logic              wp_n,
    input  logic              arr_busy,
    input  logic              op_done,
    input  logic [1:0]        op_kind,
    input  logic              op_fail,
    input  logic [1:0]        op_ecc,
    output logic [BYTE_W-1:0] feat_rdata,
    output logic              lock_wr_ok,
    output logic              launch_go,
    output logic [1:0]        launch_kind,
    output logic              abort_op
);
    localparam int GAP_W = BYTE_W - 2 - LVL_W - 1;

    regs_t r_q, r_d;
    logic [BYTE_W-1:0] prot_byte, cfg_byte, stat_byte, rd_byte;
    logic              gate_go;
    logic [1:0]        gate_kind;
    logic              unused_wbits;

    assign prot_byte = {r_q.prot.guard, {GAP_W{1'b0}}, r_q.prot.cmpl,
                        r_q.prot.inv, r_q.prot.level};
    assign cfg_byte  = {3'b000, r_q.ecc_en, 4'b0000};
    assign stat_byte = {2'b00, r_q.ecc_st, r_q.prog_fail, r_q.erase_fail,
                        r_q.wel, arr_busy};
    assign unused_wbits = ^{feat_wdata[6:5], feat_wdata[7:5] & 3'b0,
                            feat_wdata[3:0] & 4'b0};

    lock_guard u_guard (
        .guard (r_q.prot.guard),
        .wp_n  (wp_n),
        .allow (lock_wr_ok)
    );

    feat_mux #(
        .BYTE_W (BYTE_W),
        .A_PROT (ADDR_PROT),
        .A_CFG  (ADDR_CFG),
        .A_STAT (ADDR_STAT)
    ) u_mux (
        .addr      (feat_addr),
        .prot_byte (prot_byte),
        .cfg_byte  (cfg_byte),
        .stat_byte (stat_byte),
        .rbyte     (rd_byte)
    );

    op_gate u_gate (
        .wel      (r_q.wel),
        .busy     (arr_busy),
        .do_prog  (cmd_prog),
        .do_erase (cmd_erase),
        .do_read  (cmd_pgrd),
        .go       (gate_go),
        .kind     (gate_kind)
    );

    always_comb begin
        r_d             = r_q;
        r_d.launch      = gate_go;
        r_d.launch_kind = gate_kind;
        r_d.abort       = cmd_rst && arr_busy;
        if (cmd_getf) r_d.rdata = rd_byte;

        if (cmd_wren)  r_d.wel = 1'b1;
        if (cmd_wrdis) r_d.wel = 1'b0;

        if (cmd_setf) begin
            if (feat_addr == ADDR_PROT && lock_wr_ok) begin
                r_d.prot.level = feat_wdata[LVL_W-1:0];
                r_d.prot.inv   = feat_wdata[LVL_W];
                r_d.prot.cmpl  = feat_wdata[LVL_W+1];
                r_d.prot.guard = feat_wdata[BYTE_W-1];
            end
            if (feat_addr == ADDR_CFG) r_d.ecc_en = feat_wdata[4];
        end

        if (cmd_rst && !arr_busy) begin
            r_d.prog_fail  = 1'b0;
            r_d.erase_fail = 1'b0;
            r_d.ecc_st     = 2'b00;
        end

        if (op_done) begin
            case (op_kind)
                OPK_PROG: begin
                    r_d.wel       = 1'b0;
                    r_d.prog_fail = op_fail;
                end
                OPK_ERASE: begin
                    r_d.wel        = 1'b0;
                    r_d.erase_fail = op_fail;
                end
                OPK_READ: r_d.ecc_st = op_ecc;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q            <= '0;
            r_q.prot.level <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign feat_rdata  = r_q.rdata;
    assign launch_go   = r_q.launch;
    assign launch_kind = r_q.launch_kind;
    assign abort_op    = r_q.abort;

    assert_cmd_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_wren, cmd_wrdis, cmd_setf, cmd_getf, cmd_rst,
                  cmd_prog, cmd_erase, cmd_pgrd}));
    assert_wel_set_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wren && !op_done) |=> r_q.wel);
    assert_lock_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_setf && feat_addr == ADDR_PROT && r_q.prot.guard && !wp_n)
        |=> $stable(r_q.prot));
    assert_launch_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_erase && !r_q.wel) |=> !launch_go);
    assert_busy_no_launch_R6: assert property (@(posedge clk) disable iff (rst)
        arr_busy |=> !launch_go);
    assert_done_clears_wel_R7: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_kind != OPK_READ && !cmd_wren) |=> !r_q.wel);
    assert_abort_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_rst && arr_busy) |=> abort_op);
    assert_idle_no_abort_R8: assert property (@(posedge clk) disable iff (rst)
        !arr_busy |=> !abort_op);
endmodule

// File: tb/test_flash_wp_feature_regs.sv
module test_flash_wp_feature_regs;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wren = 0, cmd_wrdis = 0, cmd_setf = 0, cmd_getf = 0;
    logic cmd_rst = 0, cmd_prog = 0, cmd_erase = 0, cmd_pgrd = 0;
    logic [7:0] feat_addr = 0, feat_wdata = 0;
    logic wp_n = 1'b1, arr_busy = 1'b0, op_done = 1'b0, op_fail = 1'b0;
    logic [1:0] op_kind = 0, op_ecc = 0;
    logic [7:0] feat_rdata;
    logic lock_wr_ok, launch_go, abort_op;
    logic [1:0] launch_kind;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_prot = 8'h07, m_cfg = 8'h00, m_stat = 8'h00;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    flash_wp_feature_regs i_flash_wp_feature_regs (
        .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdis(cmd_wrdis),
        .cmd_setf(cmd_setf), .cmd_getf(cmd_getf), .cmd_rst(cmd_rst),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_pgrd(cmd_pgrd),
        .feat_addr(feat_addr), .feat_wdata(feat_wdata), .wp_n(wp_n),
        .arr_busy(arr_busy), .op_done(op_done), .op_kind(op_kind),
        .op_fail(op_fail), .op_ecc(op_ecc), .feat_rdata(feat_rdata),
        .lock_wr_ok(lock_wr_ok), .launch_go(launch_go),
        .launch_kind(launch_kind), .abort_op(abort_op)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        cmd_wren = 0; cmd_wrdis = 0; cmd_setf = 0; cmd_getf = 0;
        cmd_rst = 0; cmd_prog = 0; cmd_erase = 0; cmd_pgrd = 0; op_done = 0;
    endtask

    // strobe is raised now (after a negedge); wait to next negedge, lower it
    task automatic step();
        @(negedge clk);
        idle_all();
    endtask

    task automatic setf(input logic [7:0] a, input logic [7:0] d);
        feat_addr = a; feat_wdata = d; cmd_setf = 1; step();
    endtask

    task automatic getf(input logic [7:0] a, output logic [7:0] v);
        feat_addr = a; cmd_getf = 1; step();
        v = feat_rdata;
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'hA0) return m_prot;
        if (a == 8'hB0) return m_cfg;
        if (a == 8'hC0) return {m_stat[7:1], arr_busy};
        return 8'h00;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", feat_rdata, 0);
        chk("R1 launch", launch_go, 0);
        chk("R1 abort", abort_op, 0);
        getf(8'hA0, got); chk("R1 prot", got, 8'h07);
        getf(8'hB0, got); chk("R1 cfg", got, 8'h00);
        getf(8'hC0, got); chk("R1 stat", got, 8'h00);

        // R2 latch
        cmd_wren = 1; step();
        getf(8'hC0, got); chk("R2 wren", got, 8'h02);
        cmd_wrdis = 1; step();
        getf(8'hC0, got); chk("R2 wrdis", got, 8'h00);

        // R3/R4 sweep over guard x pin x all data bytes
        for (int g = 0; g < 2; g++) begin
            for (int w = 0; w < 2; w++) begin
                wp_n = 1'b1;
                setf(8'hA0, g ? 8'h80 : 8'h00);
                m_prot = g ? 8'h80 : 8'h00;
                wp_n = w[0];
                #0;
                chk("R4 lock_wr_ok", lock_wr_ok, (g == 1 && w == 0) ? 0 : 1);
                for (int v = 0; v < 256; v++) begin
                    setf(8'hA0, v[7:0]);
                    if (!(g == 1 && w == 0)) m_prot = v[7:0] & 8'h9F;
                    getf(8'hA0, got);
                    chk((g == 1 && w == 0) ? "R4 frozen" : "R3 stored", got, m_prot);
                    if (!(g == 1 && w == 0)) begin
                        wp_n = 1'b1;
                        setf(8'hA0, g ? 8'h80 : 8'h00);
                        m_prot = g ? 8'h80 : 8'h00;
                        wp_n = w[0];
                    end
                end
            end
        end
        wp_n = 1'b1;
        setf(8'hA0, 8'h07); m_prot = 8'h07;

        // R9 config
        setf(8'hB0, 8'hFF); m_cfg = 8'h10;
        getf(8'hB0, got); chk("R9 cfg set", got, 8'h10);
        setf(8'hB0, 8'hEF); m_cfg = 8'h00;
        getf(8'hB0, got); chk("R9 cfg clr", got, 8'h00);

        // R5 address sweep: writes to non-feature addresses and status do nothing
        for (int a = 0; a < 256; a++) begin
            if (a != 8'hA0 && a != 8'hB0) setf(a[7:0], 8'hFF);
            getf(a[7:0], got);
            chk("R5 read", got, model_read(a[7:0]));
        end

        // R6 launch gating
        cmd_erase = 1; step();
        chk("R6 no wel", launch_go, 0);
        cmd_wren = 1; step();
        arr_busy = 1; cmd_prog = 1; step();
        chk("R6 busy", launch_go, 0);
        arr_busy = 0; cmd_erase = 1; step();
        chk("R6 erase go", launch_go, 1);
        chk("R6 erase kind", launch_kind, 2);
        cmd_prog = 1; step();
        chk("R6 prog go", launch_go, 1);
        chk("R6 prog kind", launch_kind, 1);
        cmd_wrdis = 1; step();
        cmd_pgrd = 1; step();
        chk("R6 read go", launch_go, 1);
        chk("R6 read kind", launch_kind, 0);
        step();
        chk("R6 one pulse", launch_go, 0);

        // R7 completions
        cmd_wren = 1; step();
        op_done = 1; op_kind = 2'd1; op_fail = 1; step();
        getf(8'hC0, got); chk("R7 prog done", got, 8'h08);
        cmd_wren = 1; step();
        op_done = 1; op_kind = 2'd2; op_fail = 1; step();
        getf(8'hC0, got); chk("R7 erase done", got, 8'h0C);
        op_done = 1; op_kind = 2'd0; op_ecc = 2'b10; step();
        getf(8'hC0, got); chk("R7 read ecc", got, 8'h2C);

        // R8 reset command
        arr_busy = 1; cmd_rst = 1; step();
        chk("R8 abort", abort_op, 1);
        getf(8'hC0, got); chk("R8 busy keeps", got, 8'h2D);
        arr_busy = 0; cmd_rst = 1; step();
        chk("R8 idle no abort", abort_op, 0);
        getf(8'hC0, got); chk("R8 idle clears", got, 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule